// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a target on a two-wire serial bus. It gives a bus controller read and write access to a bank of byte-wide registers with 8-bit addresses. The register storage sits outside the block. The block drives a write port with a one-cycle write strobe, address and data. It also drives a read address and takes back the read data. The bus lines reach it as raw inputs. Its only bus output is a pull-low enable for the data line, because the line is open-drain.

Both bus lines pass through a synchronizer. They are then sampled by a system clock that runs at least eight times faster than the serial clock. From the sampled lines the block detects START and STOP conditions. It compares the 7-bit select code, one bit of which comes from a strap pin, so that two identical targets can share a bus. It then acknowledges the bytes it accepts.

An internal pointer keeps its value between transactions. It is loaded by the first byte of a write and advances after every data byte moved in either direction. A read that sends only the select code therefore continues from the last access. A random read is a write of the byte address, a repeated START and then a read select code.

Top module: `i2c_tgt_regs`

## Requirements
- R1: After reset the data-line pull-low enable is 0 and no write strobe is issued until a bus transaction writes a byte.
- R2: The target answers the 7-bit code equal to DEV_BASE with bit SEL_BIT replaced by the `addr_sel` pin (default 0x34/0x35, so the write/read select bytes are 0x6A/0x6B when `addr_sel`=1). On a match it pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next START or STOP, issuing no write.
- R3: In a write transfer the first byte after the select code loads the pointer and is acknowledged. Each following byte is acknowledged and written to the pointer address with a write strobe exactly one system clock long.
- R4: The pointer advances by one after every byte written and after every byte loaded for reading, wrapping from 255 to 0.
- R5: A read select code returns bytes MSB first, starting from the current pointer. A byte is driven bit by bit on falling SCL edges and followed by the next register while the controller acknowledges.
- R6: A byte-address write followed by a repeated START and a read select code returns data starting at that byte address.
- R7: A controller NACK after a read byte ends data output. SDA stays released through any further clocks until a START or STOP.
- R8: A START or STOP in the middle of a byte abandons it. A partial byte is never written and registers already written keep their values. After a START a new transaction proceeds normally.
- R9: The SDA pull-low enable changes only while the synchronized SCL is low, except for its release upon a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 1 | Strap value for the selectable select-code bit |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | ADDR_W | Register read address (current pointer) |
| rd_data | input | 8 | Register read data for rd_addr |

## Verification
The bench uses the default build: 8-bit register addresses, select base 0x34 with bit 0 strapped, and a two-stage synchronizer. It runs SCL at one sixteenth of the system clock. With these values a single multi-byte write can sweep all 256 register addresses and carry the pointer across its wrap point. Reads starting at 0xFE then check the wrap on the read side. Both strap values are tried against both select codes. Transfers are also broken off by a STOP or a START at odd bit counts, to confirm that a partial byte leaves the registers untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_REG,
        ST_WDATA,
        ST_ACK_RX,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } tgt_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [DEV_W-1:0] make_dev_id(input logic [DEV_W-1:0] base,
                                                      input int sel_bit,
                                                      input logic sel);
        logic [DEV_W-1:0] r;
        r = base;
        r[sel_bit] = sel;
        return r;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt,
    output logic     scl_lvl
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        evt.rise  = scl_s & ~scl_d;
        evt.fall  = ~scl_s & scl_d;
        evt.start = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
        evt.sda   = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [DEV_W-1:0] DEV_BASE = 7'h34,
    parameter int               SEL_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              scl_lvl,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [ADDR_W-1:0] ptr;
    logic              rd_dir;
    logic              mack_n;
    logic [DEV_W-1:0]  dev_id;

    assign dev_id  = make_dev_id(DEV_BASE, SEL_BIT, addr_sel);
    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            rd_dir  <= 1'b0;
            mack_n  <= 1'b1;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WDATA: begin
                        if (evt.rise) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], evt.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt.fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (rx_sr[BYTE_W-1:1] == dev_id) begin
                                    sda_oe <= 1'b1;
                                    rd_dir <= rx_sr[0];
                                    state  <= ST_ACK_DEV;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_REG) begin
                                ptr    <= rx_sr[ADDR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_RX;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= rx_sr;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_RX;
                            end
                        end
                    end
                    ST_ACK_DEV: begin
                        if (evt.fall) begin
                            if (rd_dir) begin
                                tx_sr   <= rd_data;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= CNT_W'(1);
                                state   <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_REG;
                            end
                        end
                    end
                    ST_ACK_RX: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_TX: begin
                        if (evt.fall) begin
                            if (bit_cnt == FULL) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                sda_oe  <= ~tx_sr[BYTE_W-2];
                                tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.rise) begin
                            mack_n <= evt.sda;
                        end else if (evt.fall) begin
                            if (!mack_n) begin
                                tx_sr   <= rd_data;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= CNT_W'(1);
                                state   <= ST_TX;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(evt.start) && !$past(evt.stop)) |-> !$past(scl_lvl));

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4
    wr_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == ADDR_W'(wr_addr + 1'b1)));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe && !wr_en));

    // R7
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && $past(state) == ST_WAIT) |-> !sda_oe);

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter logic [DEV_W-1:0] DEV_BASE    = 7'h34,
    parameter int               SEL_BIT     = 0,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    bus_evt_t evt;
    logic     scl_lvl;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_i),
        .sda_in  (sda_i),
        .evt     (evt),
        .scl_lvl (scl_lvl)
    );

    i2c_tgt_ctrl #(
        .ADDR_W   (ADDR_W),
        .DEV_BASE (DEV_BASE),
        .SEL_BIT  (SEL_BIT)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .scl_lvl  (scl_lvl),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/i2c_tgt_regs_tb_top.sv
module i2c_tgt_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b1;
    logic       sda_oe;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       sda_line;
    logic [7:0] mem [256];
    int         wr_cnt;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    i2c_tgt_regs dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            wr_cnt <= 0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input bit b);
        wt(4); sda_m = b; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wt(4); sda_m = 1'b0; wt(8); scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wt(4); sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(4); sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        wt(4); sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); nack = sda_line; wt(4); scl_m = 1'b0;
    endtask

    task automatic rbyte(input bit nack_out, output logic [7:0] v, output bit steady);
        bit a;
        steady = 1;
        for (int i = 7; i >= 0; i--) begin
            wt(4); sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(1); a = sda_line;
            wt(6); if (sda_line != a) steady = 0;
            v[i] = a; wt(1); scl_m = 1'b0;
        end
        wt(4); sda_m = nack_out; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0;
    endtask

    task automatic rd_expect(input int n, input int first, input string tag);
        logic [7:0] v;
        bit st;
        for (int k = 0; k < n; k++) begin
            rbyte(k == n - 1, v, st);
            chk(v == pat((first + k) & 255), tag, v, pat((first + k) & 255));
            chk(st, "R9 bit steady while SCL high", 0, 1);
        end
    endtask

    initial begin
        bit nk;
        int base_cnt;
        logic [7:0] v;
        bit st;
        wt(4);
        rst = 1'b0;
        wt(4);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(wr_cnt == 0, "R1 no write after reset", wr_cnt, 0);

        // R2 mismatch ignored
        bus_start();
        wbyte(8'h68, nk);
        chk(nk == 1'b1, "R2 wrong select not acked", nk, 1);
        wbyte(8'h00, nk);
        wbyte(8'h55, nk);
        chk(nk == 1'b1, "R2 ignored bytes not acked", nk, 1);
        bus_stop();
        chk(wr_cnt == 0, "R2 no write after mismatch", wr_cnt, 0);

        // R3 / R4 full sweep write
        bus_start();
        wbyte(8'h6A, nk);
        chk(nk == 1'b0, "R2 matching select acked", nk, 0);
        wbyte(8'h00, nk);
        chk(nk == 1'b0, "R3 byte address acked", nk, 0);
        for (int i = 0; i < 256; i++) begin
            wbyte(~pat(i), nk);
            chk(nk == 1'b0, "R3 data byte acked", nk, 0);
        end
        bus_stop();
        chk(wr_cnt == 256, "R3 write strobe count", wr_cnt, 256);
        for (int i = 0; i < 256; i++)
            chk(mem[i] == ~pat(i), "R3 register content", mem[i], ~pat(i));
        // restore pattern: second sweep writes pat values
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'h00, nk);
        for (int i = 0; i < 256; i++) wbyte(pat(i), nk);
        bus_stop();
        chk(wr_cnt == 512, "R3 second sweep strobes", wr_cnt, 512);

        // R5 / R4 current read after wrap
        bus_start();
        wbyte(8'h6B, nk);
        chk(nk == 1'b0, "R5 read select acked", nk, 0);
        rd_expect(3, 0, "R5 R4 current read after wrap");
        bus_stop();

        // R6 random read across wrap, then R7
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'hFE, nk);
        bus_rstart();
        wbyte(8'h6B, nk);
        chk(nk == 1'b0, "R6 read select after repeated start", nk, 0);
        rd_expect(4, 254, "R6 R4 random read");
        st = 1;
        for (int k = 0; k < 9; k++) begin
            wt(4); sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4);
            if (sda_oe) st = 0;
            wt(4); scl_m = 1'b0;
        end
        chk(st, "R7 SDA released after NACK", 0, 1);
        bus_stop();

        // R5 current read continues at 2
        bus_start();
        wbyte(8'h6B, nk);
        rd_expect(2, 2, "R5 current read continues");
        bus_stop();

        // R3 / R4 single write then current read
        base_cnt = wr_cnt;
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'h10, nk);
        wbyte(8'hA5, nk);
        bus_stop();
        chk(mem[16] == 8'hA5, "R3 single write", mem[16], 8'hA5);
        chk(wr_cnt == base_cnt + 1, "R3 single strobe", wr_cnt, base_cnt + 1);
        bus_start();
        wbyte(8'h6B, nk);
        rd_expect(1, 17, "R4 pointer after write");
        bus_stop();

        // R8 STOP mid byte
        base_cnt = wr_cnt;
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'h20, nk);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        chk(wr_cnt == base_cnt, "R8 no write on STOP mid byte", wr_cnt, base_cnt);
        chk(mem[32] == pat(32), "R8 register kept", mem[32], pat(32));
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'h20, nk);
        bus_rstart();
        wbyte(8'h6B, nk);
        rd_expect(1, 32, "R8 readback after abort");
        bus_stop();

        // R8 START mid byte
        bus_start();
        wbyte(8'h6A, nk);
        wbyte(8'h30, nk);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_rstart();
        wbyte(8'h6A, nk);
        chk(nk == 1'b0, "R8 select after START mid byte", nk, 0);
        wbyte(8'h31, nk);
        wbyte(8'h5C, nk);
        bus_stop();
        chk(mem[48] == pat(48), "R8 aborted byte not written", mem[48], pat(48));
        chk(mem[49] == 8'h5C, "R8 new transfer written", mem[49], 8'h5C);

        // R2 strap bit low
        addr_sel = 1'b0;
        wt(4);
        bus_start();
        wbyte(8'h6A, nk);
        chk(nk == 1'b1, "R2 strap 0 rejects 0x35", nk, 1);
        bus_stop();
        bus_start();
        wbyte(8'h69, nk);
        chk(nk == 1'b0, "R2 strap 0 accepts 0x34 read", nk, 0);
        rbyte(1'b1, v, st);
        chk(v == pat(50), "R2 R5 read via strap 0", v, pat(50));
        bus_stop();

        done = 1;
        summary();
        $finish;
    end

endmodule